// File: doc/BRIEF.md
# Five-Way Mode-Selectable Command Arbiter

This block decides which of five requesters may drive a shared command path next. Requesters 0 to 3 are engine ports and requester 4 is the processor port. A 2-bit mode input selects the scheme at run time, and the mode may change between any two cycles. Mode 0 gives a fair rotation. Mode 1 gives a fixed order with engine 0 on top. Mode 2 gives the same order turned upside down.

The winner is registered and presented as a one-hot grant, a binary index and a valid flag. The downstream path pulses accept in a cycle where grant-valid is high to take the command. The grant then stays frozen until that accept arrives, even if requests or mode change in the meantime. The rotation pointer records the last requester whose grant was accepted, and it moves only on an accept.

Top module: `cmd_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, grant_valid is 0, grant is all zeros and the rotation pointer refers to requester 4, so the first rotating search begins at requester 0.
- R2: In mode 1, a new grant goes to the lowest-numbered active request, so the order is engine 0, 1, 2, 3 and then the processor (index 4).
- R3: In mode 2, a new grant goes to the highest-numbered active request, so the order is processor (index 4), engine 3, 2, 1 and then 0.
- R4: In mode 0, a new grant goes to the first active request found by scanning upward from the index just after the last accepted requester, wrapping from 4 to 0.
- R5: Mode 3 selects grants exactly as mode 0 does.
- R6: While grant_valid is 1 and accept is 0, grant and grant_idx keep their values and grant_valid stays 1, whatever req and mode do.
- R7: The rotation pointer changes only in a cycle where grant_valid and accept are both 1, and it then takes the accepted index. Cycles spent holding, and cycles with no grant, leave it unchanged.
- R8: A new selection is made when grant_valid is 0 or accept is 1. If req is all zeros at that edge, grant_valid is 0 in the next cycle and the pointer does not move.
- R9: grant is zero or one-hot, it is non-zero exactly when grant_valid is 1, and it is set at bit grant_idx. A new grant always names a requester that was active at the edge where it was selected.
- R10: A grant is registered. It appears in the cycle after the edge that samples the request, never in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 5 | Request lines; bits 0-3 are engines, bit 4 is the processor |
| mode | input | 2 | 0 rotate, 1 forward priority, 2 reverse priority, 3 rotate |
| accept | input | 1 | Downstream takes the current grant (meaningful when grant_valid is 1) |
| grant | output | 5 | One-hot grant |
| grant_valid | output | 1 | A grant is being presented |
| grant_idx | output | 3 | Binary index of the granted requester (meaningful when grant_valid is 1) |

## Verification
The hardest situation to reach is one where the rotating search starts from a pointer set by an earlier accept that was made in a different mode. The same situation arises when a long hold, with requests and mode changing underneath it, must leave the pointer where it was. The bench sweeps every request pattern in all four modes with accept tied high, so that each accept moves the pointer. It then runs a long pseudo-random sequence where accept is low in about half the cycles and the mode and requests change on every cycle. A reference model kept in the bench predicts each grant from the requirements alone.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;

    localparam int ENGINE_PORTS = 4;

    typedef enum logic [1:0] {
        ARB_ROTATE     = 2'd0,
        ARB_FWD_PRIO   = 2'd1,
        ARB_REV_PRIO   = 2'd2,
        ARB_ROTATE_ALT = 2'd3
    } arb_mode_e;

    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
    parameter  int N = 5,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] idx
);
    int unsigned cand;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = 0;
        for (int k = 0; k < N; k++) begin
            cand = int'(start) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand[W-1:0]]) begin
                found = 1'b1;
                idx   = cand[W-1:0];
            end
        end
    end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter  int N       = 5,
    parameter  bit REVERSE = 1'b0,
    localparam int W       = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    assign found = |req;

    generate
        if (REVERSE) begin : g_high_first
            always_comb begin
                idx = '0;
                for (int k = 0; k < N; k++)
                    if (req[k]) idx = W'(k);
            end
        end else begin : g_low_first
            always_comb begin
                idx = '0;
                for (int k = N - 1; k >= 0; k--)
                    if (req[k]) idx = W'(k);
            end
        end
    endgenerate
endmodule

// File: rtl/cmd_arbiter.sv
module cmd_arbiter
    import cmd_arb_pkg::*;
#(
    parameter  int N_ENG = ENGINE_PORTS,
    localparam int N_REQ = N_ENG + 1,
    localparam int W     = $clog2(N_REQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic [1:0]       mode,
    input  logic             accept,
    output logic [N_REQ-1:0] grant,
    output logic             grant_valid,
    output logic [W-1:0]     grant_idx
);
    logic [W-1:0] rr_ptr;
    logic [W-1:0] rr_base;
    logic [W-1:0] rr_start;
    logic         take;
    logic         reload;

    logic         rot_found, fwd_found, rev_found, sel_found;
    logic [W-1:0] rot_idx, fwd_idx, rev_idx, sel_idx;

    assign take     = grant_valid && accept;
    assign reload   = !grant_valid || accept;
    assign rr_base  = take ? grant_idx : rr_ptr;
    assign rr_start = W'(wrap_next(int'(rr_base), N_REQ));

    arb_rot_pick #(.N(N_REQ)) u_rot (
        .req   (req),
        .start (rr_start),
        .found (rot_found),
        .idx   (rot_idx)
    );

    arb_prio_pick #(.N(N_REQ), .REVERSE(1'b0)) u_fwd (
        .req   (req),
        .found (fwd_found),
        .idx   (fwd_idx)
    );

    arb_prio_pick #(.N(N_REQ), .REVERSE(1'b1)) u_rev (
        .req   (req),
        .found (rev_found),
        .idx   (rev_idx)
    );

    always_comb begin
        case (arb_mode_e'(mode))
            ARB_FWD_PRIO: begin sel_found = fwd_found; sel_idx = fwd_idx; end
            ARB_REV_PRIO: begin sel_found = rev_found; sel_idx = rev_idx; end
            default:      begin sel_found = rot_found; sel_idx = rot_idx; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
            rr_ptr      <= W'(N_REQ - 1);
        end else begin
            if (take)
                rr_ptr <= grant_idx;
            if (reload) begin
                grant_valid <= sel_found;
                if (sel_found)
                    grant_idx <= sel_idx;
            end
        end
    end

    always_comb begin
        grant = '0;
        if (grant_valid)
            grant[grant_idx] = 1'b1;
    end
endmodule

// File: rtl/cmd_arbiter_chk.sv
module cmd_arbiter_chk #(
    parameter int N_REQ = 5,
    parameter int W     = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_REQ-1:0] req,
    input logic [1:0]       mode,
    input logic             accept,
    input logic [N_REQ-1:0] grant,
    input logic             grant_valid,
    input logic [W-1:0]     grant_idx,
    input logic [W-1:0]     rr_ptr
);
    // R9: grant shape agrees with grant_valid
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (grant_valid == (grant != '0)));

    // R9: a freshly selected grant names a requester active at selection
    a_r9_granted_req: assert property (@(posedge clk) disable iff (rst)
        ((!grant_valid || accept) && (req != '0)) |=> (grant_valid && ((grant & $past(req)) != '0)));

    // R8: no requests at a selection edge gives no grant
    a_r8_no_req: assert property (@(posedge clk) disable iff (rst)
        ((!grant_valid || accept) && (req == '0)) |=> !grant_valid);

    // R6: hold until accepted
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !accept) |=> (grant_valid && $stable(grant_idx)));

    // R7: pointer moves only on accept
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(grant_valid && accept) |=> $stable(rr_ptr));

    // R7: pointer takes the accepted index
    a_r7_ptr_take: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && accept) |=> (rr_ptr == $past(grant_idx)));

    // R2: engine 0 wins forward priority
    a_r2_fwd_top: assert property (@(posedge clk) disable iff (rst)
        ((!grant_valid || accept) && (mode == 2'd1) && req[0]) |=> grant[0]);

    // R3: processor wins reverse priority
    a_r3_rev_top: assert property (@(posedge clk) disable iff (rst)
        ((!grant_valid || accept) && (mode == 2'd2) && req[N_REQ-1]) |=> grant[N_REQ-1]);
endmodule

bind cmd_arbiter cmd_arbiter_chk #(.N_REQ(N_REQ), .W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .mode        (mode),
    .accept      (accept),
    .grant       (grant),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .rr_ptr      (rr_ptr)
);

// File: tb/cmd_arbiter_tb_top.sv
`timescale 1ns/1ps
module cmd_arbiter_tb_top;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [1:0]   mode = 2'd0;
    logic         accept = 1'b0;
    logic [N-1:0] grant;
    logic         grant_valid;
    logic [2:0]   grant_idx;

    int checks = 0;
    int errors = 0;

    // reference state
    bit m_gv = 0;
    int m_idx = 0;
    int m_ptr = N - 1;

    always #4 clk = ~clk;

    cmd_arbiter dut_i (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .mode        (mode),
        .accept      (accept),
        .grant       (grant),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    function automatic int ref_pick(input logic [N-1:0] r, input logic [1:0] m, input int start);
        int res = -1;
        if (m == 2'd1) begin
            for (int k = N - 1; k >= 0; k--) if (r[k]) res = k;
        end else if (m == 2'd2) begin
            for (int k = 0; k < N; k++) if (r[k]) res = k;
        end else begin
            for (int k = N - 1; k >= 0; k--) if (r[(start + k) % N]) res = (start + k) % N;
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [1:0] m, input bit a, input string force_tag);
        bit reload, take;
        int base;
        string tag;
        logic [N-1:0] exp_grant;
        req = r; mode = m; accept = a;
        reload = !m_gv || a;
        take = m_gv && a;
        base = take ? m_idx : m_ptr;
        if (take) m_ptr = m_idx;
        if (!reload)           tag = "R6";
        else if (r == '0)      tag = "R8";
        else if (m == 2'd1)    tag = "R2";
        else if (m == 2'd2)    tag = "R3";
        else if (m == 2'd3)    tag = "R5";
        else                   tag = "R4";
        if (force_tag != "") tag = force_tag;
        if (reload) begin
            m_gv = (r != '0);
            if (m_gv) m_idx = ref_pick(r, m, (base + 1) % N);
        end
        exp_grant = m_gv ? (N'(1) << m_idx) : '0;
        @(posedge clk);
        #2;
        check(tag, grant, exp_grant);
        check("R9", {4'b0, grant_valid}, {4'b0, m_gv});
        if (m_gv) check("R9", {2'b0, grant_idx}, N'(m_idx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #2;
        check("R1", grant, '0);
        check("R1", {4'b0, grant_valid}, '0);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", {4'b0, grant_valid}, '0);

        // R10: request raised between edges is not granted before the next edge
        req = 5'b00100;
        #1;
        check("R10", {4'b0, grant_valid}, '0);
        req = '0;

        // R1: first rotating search starts at requester 0
        step(5'b11111, 2'd0, 1'b0, "R1");

        // R6 / R7: hold while req and mode move, then accept
        step(5'b00000, 2'd1, 1'b0, "R6");
        step(5'b10000, 2'd2, 1'b0, "R6");
        step(5'b11110, 2'd0, 1'b1, "R7");
        step(5'b11111, 2'd0, 1'b0, "R7");
        step(5'b11111, 2'd0, 1'b1, "R7");

        // exhaustive sweep of request patterns in every mode, always accepting
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 32; r++)
                step(N'(r), 2'(m), 1'b1, "");

        // R4: full rotation with every requester active
        for (int k = 0; k < 10; k++) step(5'b11111, 2'd0, 1'b1, "R4");

        // R8: no requests, then the pointer must be where the last accept left it
        step(5'b00000, 2'd0, 1'b1, "R8");
        step(5'b00000, 2'd0, 1'b0, "R8");
        step(5'b11111, 2'd3, 1'b0, "R8");

        // pseudo-random mix with holds
        lfsr = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            step(lfsr[20:16], lfsr[25:24], lfsr[28], "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule